// File: doc/BRIEF.md
# Character-Based CRT Timing Controller

This block produces raster timing for a monitor and a linear display memory address. It works from a dot clock and groups the dots into character cells. A cell is 8 dots wide, or 9 dots wide in text mode when the wide-cell option is set. A horizontal counter counts character cells along a line. A vertical counter counts scan lines in a frame. Horizontal sync, vertical sync, blank and display enable come from comparing these counters with programmable 8-bit values.

Software writes sixteen 8-bit registers through a simple write port. The writes go into a shadow bank. The active bank copies the whole shadow bank at the frame boundary, so a frame never runs with a mix of old and new settings. The memory address is a per-line base plus the current character count. The base restarts from a programmable start address at every frame and grows by a programmable offset on each new line.

Top module: `crt_timing`

## Requirements
- R1: While reset is asserted and right after it is released, all registers are zero, hsync_o, vsync_o and blank_o are low, addr_o is 0 and de_o is high, because character 0 of line 0 is within a display end of 0.
- R2: A character cell is 9 dot clocks when mode register 15 has bit 0 (text) and bit 1 (wide cell) both set, and 8 dot clocks otherwise. Graphics mode (bit 0 clear) always uses 8 dots, whatever bit 1 holds.
- R3: The horizontal counter runs from 0 to register 0 (last character) and then wraps. The vertical counter advances on each horizontal wrap and runs from 0 to register 6 (last line). A line therefore lasts (reg0+1) cells.
- R4: de_o is high exactly when the character count is at most register 1 and the line count is at most register 7.
- R5: Horizontal blank turns on at the character equal to register 2. It turns off at the first later character whose low 6 bits equal the low 6 bits of register 3. The pulse may wrap past the line total. The start match wins when both match.
- R6: hsync_o turns on at the character equal to register 4. It turns off at the first later character whose low 4 bits equal the low 4 bits of register 5, and it may wrap past the line total.
- R7: Vertical blank turns on at the line equal to register 8 and off at the line equal to register 9. vsync_o turns on at the line equal to register 10 and off at the line whose low 4 bits equal the low 4 bits of register 11.
- R8: blank_o is the OR of horizontal blank and vertical blank.
- R9: addr_o equals line base plus character count, modulo 2^16. The base loads {reg13, reg12} at frame start and adds register 14 at each other line start.
- R10: A write to register wr_addr_i takes effect only at the next frame boundary, which is the end of the last character of the last line. Until then the running frame keeps its old timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register index |
| wr_data_i | input | 8 | Register write data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| blank_o | output | 1 | Combined blanking |
| de_o | output | 1 | Display enable |
| addr_o | output | 16 | Display memory address |

## Verification
The bench starts from the all-zero register state. There every character ends a line and a frame, so pulse start matches win on every cell. It then loads a timing set whose horizontal blank and sync wrap past the line total, and later a set whose pulses sit inside the line. Comparing the two shows whether the low-bit end compare and the wrap are handled. Line periods are measured in text mode with wide cells, and in graphics mode with the wide-cell bit still set. This separates the 9-dot case from the graphics override. A line total written in the middle of a frame must leave the current line length unchanged, which shows whether the frame-boundary load holds back the write.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int REG_W  = 8;
  localparam int NREG   = 16;
  localparam int IDX_W  = $clog2(NREG);
  localparam int ADDR_W = 2 * REG_W;

  localparam int RI_HTOT  = 0;
  localparam int RI_HDE   = 1;
  localparam int RI_HBS   = 2;
  localparam int RI_HBE   = 3;
  localparam int RI_HSS   = 4;
  localparam int RI_HSE   = 5;
  localparam int RI_VTOT  = 6;
  localparam int RI_VDE   = 7;
  localparam int RI_VBS   = 8;
  localparam int RI_VBE   = 9;
  localparam int RI_VSS   = 10;
  localparam int RI_VSE   = 11;
  localparam int RI_SA_LO = 12;
  localparam int RI_SA_HI = 13;
  localparam int RI_OFS   = 14;
  localparam int RI_MODE  = 15;

  localparam int HB_END_W = 6;
  localparam int HS_END_W = 4;
  localparam int VB_END_W = REG_W;
  localparam int VS_END_W = 4;

  typedef logic [NREG-1:0][REG_W-1:0] reg_bank_t;
endpackage

// File: rtl/crt_regs.sv
module crt_regs
  import crt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             load_i,
  output reg_bank_t        shadow_o,
  output reg_bank_t        active_o
);
  reg_bank_t sh_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (wr_en_i) begin
      sh_q[wr_addr_i] <= wr_data_i;
    end
  end

  // whole bank swaps at frame boundary only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else if (load_i) act_q <= sh_q;
  end

  assign shadow_o = sh_q;
  assign active_o = act_q;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> act_q == $past(sh_q));
endmodule

// File: rtl/crt_hv_counter.sv
module crt_hv_counter #(
  parameter int CNT_W = 8,
  parameter int DOT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wide_i,
  input  logic [CNT_W-1:0] h_total_i,
  input  logic [CNT_W-1:0] v_total_i,
  output logic             char_end_o,
  output logic             line_end_o,
  output logic             frame_end_o,
  output logic [CNT_W-1:0] h_o,
  output logic [CNT_W-1:0] v_o,
  output logic [CNT_W-1:0] h_nxt_o,
  output logic [CNT_W-1:0] v_nxt_o
);
  logic [DOT_W-1:0] dot_q, dot_last;
  logic [CNT_W-1:0] h_q, v_q;

  assign dot_last    = wide_i ? DOT_W'(8) : DOT_W'(7);
  assign char_end_o  = (dot_q == dot_last);
  assign line_end_o  = char_end_o && (h_q == h_total_i);
  assign frame_end_o = line_end_o && (v_q == v_total_i);
  assign h_nxt_o     = (h_q == h_total_i) ? '0 : h_q + 1'b1;
  assign v_nxt_o     = (v_q == v_total_i) ? '0 : v_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_q <= '0;
      h_q   <= '0;
      v_q   <= '0;
    end else begin
      dot_q <= char_end_o ? '0 : dot_q + 1'b1;
      if (char_end_o) h_q <= h_nxt_o;
      if (line_end_o) v_q <= v_nxt_o;
    end
  end

  assign h_o = h_q;
  assign v_o = v_q;

  p_dot_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_q <= dot_last);
  p_h_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_q <= h_total_i);
  p_v_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_o |=> $stable(v_q));
endmodule

// File: rtl/crt_pulse.sv
// Set on start match, clear on low-bit end match; used for R5, R6 and R7.
module crt_pulse #(
  parameter int CNT_W = 8,
  parameter int END_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] end_i,
  output logic             flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (step_i) begin
      if (cnt_nxt_i == start_i) flag_q <= 1'b1;
      else if (cnt_nxt_i[END_W-1:0] == end_i[END_W-1:0]) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  p_set_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && (cnt_nxt_i == start_i) |=> flag_o);
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(flag_o));
endmodule

// File: rtl/crt_addr_gen.sv
module crt_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int OFS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_end_i,
  input  logic              frame_end_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [CNT_W-1:0]  h_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (frame_end_i) base_q <= start_i;
    else if (line_end_i) base_q <= base_q + ADDR_W'(offset_i);
  end

  assign addr_o = base_q + ADDR_W'(h_i);

  p_base_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_i |=> $stable(base_q));
  p_frame_base_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> base_q == $past(start_i));
endmodule

// File: rtl/crt_timing.sv
module crt_timing
  import crt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              blank_o,
  output logic              de_o,
  output logic [ADDR_W-1:0] addr_o
);
  reg_bank_t sh, act;
  logic wide, char_end, line_end, frame_end;
  logic [REG_W-1:0] h_cnt, v_cnt, h_nxt, v_nxt;
  logic hblank, vblank, hsync, vsync;

  crt_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i(frame_end), .shadow_o(sh), .active_o(act)
  );

  assign wide = act[RI_MODE][0] & act[RI_MODE][1];

  crt_hv_counter #(.CNT_W(REG_W)) u_cnt (
    .clk_i, .rst_ni, .wide_i(wide),
    .h_total_i(act[RI_HTOT]), .v_total_i(act[RI_VTOT]),
    .char_end_o(char_end), .line_end_o(line_end), .frame_end_o(frame_end),
    .h_o(h_cnt), .v_o(v_cnt), .h_nxt_o(h_nxt), .v_nxt_o(v_nxt)
  );

  crt_pulse #(.CNT_W(REG_W), .END_W(HB_END_W)) u_hblank (
    .clk_i, .rst_ni, .step_i(char_end), .cnt_nxt_i(h_nxt),
    .start_i(act[RI_HBS]), .end_i(act[RI_HBE]), .flag_o(hblank));
  crt_pulse #(.CNT_W(REG_W), .END_W(HS_END_W)) u_hsync (
    .clk_i, .rst_ni, .step_i(char_end), .cnt_nxt_i(h_nxt),
    .start_i(act[RI_HSS]), .end_i(act[RI_HSE]), .flag_o(hsync));
  crt_pulse #(.CNT_W(REG_W), .END_W(VB_END_W)) u_vblank (
    .clk_i, .rst_ni, .step_i(line_end), .cnt_nxt_i(v_nxt),
    .start_i(act[RI_VBS]), .end_i(act[RI_VBE]), .flag_o(vblank));
  crt_pulse #(.CNT_W(REG_W), .END_W(VS_END_W)) u_vsync (
    .clk_i, .rst_ni, .step_i(line_end), .cnt_nxt_i(v_nxt),
    .start_i(act[RI_VSS]), .end_i(act[RI_VSE]), .flag_o(vsync));

  // next-frame start address comes from the shadow bank being loaded
  crt_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(REG_W), .OFS_W(REG_W)) u_addr (
    .clk_i, .rst_ni, .line_end_i(line_end), .frame_end_i(frame_end),
    .start_i({sh[RI_SA_HI], sh[RI_SA_LO]}), .offset_i(act[RI_OFS]),
    .h_i(h_cnt), .addr_o(addr_o)
  );

  assign hsync_o = hsync;
  assign vsync_o = vsync;
  assign blank_o = hblank | vblank;
  assign de_o    = (h_cnt <= act[RI_HDE]) && (v_cnt <= act[RI_VDE]);

  p_de_blank_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_cnt > act[RI_VDE]) |-> !de_o);
  p_vsync_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end |=> $stable(vsync_o));
endmodule

// File: tb/tb_crt_timing.sv
`timescale 1ns/1ps
module tb_crt_timing;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic hsync_o, vsync_o, blank_o, de_o;
  logic [15:0] addr_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  crt_timing dut (.*);

  // behavioural reference
  int m_sh[16];
  int m_act[16];
  int m_dot, m_h, m_v, m_base;
  bit m_hb, m_hs, m_vb, m_vs;

  function automatic bit pf(bit f, int c, int s, int e, int mask);
    if (c == s) return 1'b1;
    if ((c & mask) == (e & mask)) return 1'b0;
    return f;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) begin m_sh[i] = 0; m_act[i] = 0; end
      m_dot = 0; m_h = 0; m_v = 0; m_base = 0;
      m_hb = 0; m_hs = 0; m_vb = 0; m_vs = 0;
    end else begin
      int cw, hn, vn;
      bit ce, le, fe;
      cw = ((m_act[15] & 3) == 3) ? 9 : 8;
      ce = (m_dot == cw - 1);
      le = ce && (m_h == m_act[0]);
      fe = le && (m_v == m_act[6]);
      if (ce) begin
        hn = le ? 0 : m_h + 1;
        m_hb = pf(m_hb, hn, m_act[2], m_act[3], 63);
        m_hs = pf(m_hs, hn, m_act[4], m_act[5], 15);
        m_h = hn;
      end
      if (le) begin
        vn = fe ? 0 : m_v + 1;
        m_vb = pf(m_vb, vn, m_act[8], m_act[9], 255);
        m_vs = pf(m_vs, vn, m_act[10], m_act[11], 15);
        m_v = vn;
        m_base = fe ? (m_sh[13] * 256 + m_sh[12]) : ((m_base + m_act[14]) & 16'hFFFF);
      end
      if (fe) for (int i = 0; i < 16; i++) m_act[i] = m_sh[i];
      m_dot = ce ? 0 : m_dot + 1;
      if (wr_en_i) m_sh[wr_addr_i] = int'(wr_data_i);
    end
  end

  task automatic chk(string req, string what, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act_v, exp_v, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R6", "hsync_o", int'(hsync_o), int'(m_hs));
      chk("R7", "vsync_o", int'(vsync_o), int'(m_vs));
      chk("R8 R5 R7", "blank_o", int'(blank_o), int'(m_hb | m_vb));
      chk("R4", "de_o", int'(de_o), int'((m_h <= m_act[1]) && (m_v <= m_act[7])));
      chk("R9", "addr_o", int'(addr_o), (m_base + m_h) & 16'hFFFF);
    end
  end

  // watchdog
  always @(negedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = 8'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic hperiod(output int n);
    int c;
    while (hsync_o) @(negedge clk_i);
    while (!hsync_o) @(negedge clk_i);
    c = 0;
    while (hsync_o) begin @(negedge clk_i); c++; end
    while (!hsync_o) begin @(negedge clk_i); c++; end
    n = c;
  endtask

  task automatic vrise();
    while (vsync_o) @(negedge clk_i);
    while (!vsync_o) @(negedge clk_i);
  endtask

  task automatic frames(int k);
    for (int i = 0; i < k; i++) vrise();
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk_i);
    chk("R1", "hsync_o in reset", int'(hsync_o), 0);
    chk("R1", "blank_o in reset", int'(blank_o), 0);
    rst_ni = 1'b1;
    chk("R1", "hsync_o", int'(hsync_o), 0);
    chk("R1", "vsync_o", int'(vsync_o), 0);
    chk("R1", "blank_o", int'(blank_o), 0);
    chk("R1", "de_o", int'(de_o), 1);
    chk("R1", "addr_o", int'(addr_o), 0);

    // pattern A: wrapping horizontal pulses, text mode, wide cells
    wr(0, 9);  wr(1, 7);  wr(2, 8);  wr(3, 1);  wr(4, 9);  wr(5, 2);
    wr(6, 20); wr(7, 15); wr(8, 16); wr(9, 19); wr(10, 17); wr(11, 18);
    wr(12, 8'h00); wr(13, 8'h01); wr(14, 10); wr(15, 3);
    frames(2);
    hperiod(n); chk("R2 R3", "text wide line dots", n, 90);

    // graphics mode ignores the wide-cell bit
    wr(15, 2);
    frames(2);
    hperiod(n); chk("R2", "graphics line dots", n, 80);
    wr(15, 0);
    frames(2);
    hperiod(n); chk("R2", "graphics narrow line dots", n, 80);

    // mid-frame write of line total
    wr(15, 3);
    frames(2);
    vrise();
    wr(0, 14);
    hperiod(n); chk("R10", "line dots before frame boundary", n, 90);
    frames(2);
    hperiod(n); chk("R3 R10", "line dots after frame boundary", n, 135);

    // pattern B: pulses inside the line, new start and offset
    wr(2, 11); wr(3, 14); wr(4, 12); wr(5, 13); wr(1, 10);
    wr(12, 8'hF0); wr(13, 8'hFF); wr(14, 33);
    frames(3);
    hperiod(n); chk("R3", "pattern B line dots", n, 135);

    repeat (50) @(negedge clk_i);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule